// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer sitting on a simple 32-bit register bus. Software must keep it alive by writing a refresh key to the counter register; if the count reaches the programmed limit first, the block raises a sticky timeout flag and pulses a reset request for one clock. Every change to the configuration is guarded. A magic key written to the counter register opens a short unlock window, and only inside that window are writes to the control register and the limit register accepted.

Keys come in two forms, selected by a control bit: one full 32-bit word, or two ordered 16-bit halves written back to back. A configuration write does not take effect at once. The new settings are held in a pending state until three watchdog clock ticks have passed. During that time a completion bit reads 0, and it reads 1 once the settings are live.

The watchdog clock is supplied as a one-cycle tick enable in the bus clock domain. An optional divide-by-256 prescaler slows the count by a further factor.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x00000420, the counter (0x4) reads 0, the limit (0x8) reads the LIMIT_RST parameter, and the reset output is low.
- R2: With the full-word key bit (control bit 13) set, one write of 0xD928C520 to offset 0x4 opens the unlock window, which shows as control bit 11 reading 1. Separate 16-bit halves do not open it in this mode.
- R3: With control bit 13 clear, the window opens only when 0x0000C520 is written to 0x4 and the very next write to 0x4 is 0x0000D928. A write of any other value between them, or the halves in reverse order, cancels the sequence.
- R4: While the window is closed, writes to the control register and to the limit register leave their stored contents unchanged.
- R5: The window closes 255 clocks after the unlock write, or at the first write to the control register that it accepts. A write to the limit register does not close it.
- R6: After an accepted configuration write, control bit 10 reads 0 until three tick cycles have passed, and then reads 1. The counter keeps running on the old settings until that moment.
- R7: When the enable bit (control bit 7) is live, the counter advances by one on each tick. When the prescaler bit (control bit 12) is also live, it advances once every 256 ticks.
- R8: On the step at which the counter would reach the limit value, the counter returns to 0, the flag (control bit 14) is set, and the reset output is high for exactly one clock.
- R9: A refresh key (0xB480A602 in full-word mode, or 0x0000A602 followed by 0x0000B480 in half mode) clears the counter and the prescaler. A wrong key leaves both unchanged.
- R10: Writing 1 to control bit 14 clears the flag, whether or not the window is open.
- R11: Once a configuration with control bit 5 equal to 0 has been written, unlock keys are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_tick | input | 1 | One-cycle enable marking a watchdog clock tick |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdog_rst | output | 1 | One-clock reset request on timeout |

## Verification
The unlock checker is exercised with halves in reverse order, with a foreign value placed between two good halves, with a wrong second half, and with half keys sent while in full-word mode. This shows that only the exact ordered pair opens the window, and that a partial match is dropped rather than held. The counter is run without the prescaler, then with it, and then fed a refresh in the middle of a prescale period. Those cases separate one step per tick from one step per 256 ticks, and show whether a refresh also clears the partial prescale count. Tick counts are placed exactly one short of and exactly on the completion delay and the timeout, which pins down the cycle in which each change appears.

// File: rtl/kgw_pkg.sv
package kgw_pkg;

    // Bit positions inside the control word (fixed by software layout)
    localparam int B_FLAG  = 14;
    localparam int B_KEY32 = 13;
    localparam int B_DIV   = 12;
    localparam int B_OPEN  = 11;
    localparam int B_DONE  = 10;
    localparam int B_CSEL  = 8;
    localparam int B_RUN   = 7;
    localparam int B_UPD   = 5;
    localparam int B_WAITR = 1;
    localparam int B_STOPR = 0;

    localparam logic [31:0] KEY_OPEN_W  = 32'hD928_C520;
    localparam logic [31:0] KEY_FEED_W  = 32'hB480_A602;
    localparam logic [15:0] KEY_OPEN_LO = 16'hC520;
    localparam logic [15:0] KEY_OPEN_HI = 16'hD928;
    localparam logic [15:0] KEY_FEED_LO = 16'hA602;
    localparam logic [15:0] KEY_FEED_HI = 16'hB480;

    typedef struct packed {
        logic       key32;
        logic       div_en;
        logic [1:0] clk_sel;
        logic       run_en;
        logic       upd_ok;
        logic       wait_run;
        logic       stop_run;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{key32: 1'b0, div_en: 1'b0, clk_sel: 2'b00,
                                   run_en: 1'b0, upd_ok: 1'b1,
                                   wait_run: 1'b0, stop_run: 1'b0};

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_OPEN_HALF,
        SEQ_FEED_HALF
    } seq_e;

    function automatic cfg_t cfg_from_word(input logic [31:0] w);
        cfg_t c;
        c.key32    = w[B_KEY32];
        c.div_en   = w[B_DIV];
        c.clk_sel  = w[B_CSEL+1:B_CSEL];
        c.run_en   = w[B_RUN];
        c.upd_ok   = w[B_UPD];
        c.wait_run = w[B_WAITR];
        c.stop_run = w[B_STOPR];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_word(input cfg_t c, input logic flag,
                                              input logic open, input logic done);
        logic [31:0] w;
        w = '0;
        w[B_FLAG]            = flag;
        w[B_KEY32]           = c.key32;
        w[B_DIV]             = c.div_en;
        w[B_OPEN]            = open;
        w[B_DONE]            = done;
        w[B_CSEL+1:B_CSEL]   = c.clk_sel;
        w[B_RUN]             = c.run_en;
        w[B_UPD]             = c.upd_ok;
        w[B_WAITR]           = c.wait_run;
        w[B_STOPR]           = c.stop_run;
        return w;
    endfunction

    function automatic logic is_half(input logic [31:0] w, input logic [15:0] k);
        return w == {16'h0000, k};
    endfunction

endpackage

// File: rtl/kgw_keyseq.sv
module kgw_keyseq
    import kgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        key32,
    output logic        unlock_o,
    output logic        feed_o
);

    seq_e state_q, state_d;

    always_comb begin
        unlock_o = 1'b0;
        feed_o   = 1'b0;
        state_d  = state_q;
        if (key32) begin
            state_d = SEQ_IDLE;
            if (key_wr) begin
                unlock_o = (key_data == KEY_OPEN_W);
                feed_o   = (key_data == KEY_FEED_W);
            end
        end else if (key_wr) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (is_half(key_data, KEY_OPEN_LO))      state_d = SEQ_OPEN_HALF;
                    else if (is_half(key_data, KEY_FEED_LO)) state_d = SEQ_FEED_HALF;
                    else                                     state_d = SEQ_IDLE;
                end
                SEQ_OPEN_HALF: begin
                    unlock_o = is_half(key_data, KEY_OPEN_HI);
                    state_d  = SEQ_IDLE;
                end
                SEQ_FEED_HALF: begin
                    feed_o  = is_half(key_data, KEY_FEED_HI);
                    state_d = SEQ_IDLE;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // R3: a half-mode unlock can only complete from the first-half state
    assert_half_order_R3: assert property (@(posedge clk) disable iff (rst)
        (unlock_o && !key32) |-> (state_q == SEQ_OPEN_HALF));

    // R9: a half-mode refresh can only complete from the first-half state
    assert_feed_order_R9: assert property (@(posedge clk) disable iff (rst)
        (feed_o && !key32) |-> (state_q == SEQ_FEED_HALF));

endmodule

// File: rtl/kgw_cfg.sv
module kgw_cfg
    import kgw_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter int          OPEN_CYC   = 255,
    parameter int          SYNC_TICKS = 3,
    parameter logic [15:0] LIMIT_RST  = 16'h1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             unlock_req,
    input  logic             ctrl_wr,
    input  logic             limit_wr,
    input  logic [31:0]      wdata,
    output cfg_t             cfg_q,
    output logic [CNT_W-1:0] limit_q,
    output logic             act_run,
    output logic             act_div,
    output logic             act_key32,
    output logic [CNT_W-1:0] act_limit,
    output logic             open_o,
    output logic             done_o,
    output logic             apply_o
);

    localparam int WIN_W  = $clog2(OPEN_CYC + 1);
    localparam int SYNC_W = $clog2(SYNC_TICKS + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(OPEN_CYC - 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_TICKS - 1);

    logic [WIN_W-1:0]  win_q;
    logic [SYNC_W-1:0] sync_q;
    logic              busy_q;
    logic              unlock_ok;
    logic              take_ctrl;
    logic              take_limit;

    assign unlock_ok  = unlock_req && cfg_q.upd_ok;
    assign take_ctrl  = open_o && ctrl_wr;
    assign take_limit = open_o && limit_wr;
    assign apply_o    = busy_q && tick && (sync_q == SYNC_LAST);
    assign done_o     = !busy_q;

    // Unlock window
    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            win_q  <= '0;
        end else if (unlock_ok) begin
            open_o <= 1'b1;
            win_q  <= '0;
        end else if (take_ctrl) begin
            open_o <= 1'b0;
        end else if (open_o) begin
            if (win_q == WIN_LAST) open_o <= 1'b0;
            else                   win_q  <= win_q + 1'b1;
        end
    end

    // Stored settings, pending until the completion delay elapses
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            limit_q   <= LIMIT_RST[CNT_W-1:0];
            act_run   <= CFG_RESET.run_en;
            act_div   <= CFG_RESET.div_en;
            act_key32 <= CFG_RESET.key32;
            act_limit <= LIMIT_RST[CNT_W-1:0];
            busy_q    <= 1'b0;
            sync_q    <= '0;
        end else begin
            if (take_ctrl)  cfg_q   <= cfg_from_word(wdata);
            if (take_limit) limit_q <= wdata[CNT_W-1:0];
            if (take_ctrl || take_limit) begin
                busy_q <= 1'b1;
                sync_q <= '0;
            end else if (apply_o) begin
                busy_q    <= 1'b0;
                act_run   <= cfg_q.run_en;
                act_div   <= cfg_q.div_en;
                act_key32 <= cfg_q.key32;
                act_limit <= limit_q;
            end else if (busy_q && tick) begin
                sync_q <= sync_q + 1'b1;
            end
        end
    end

    assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !open_o |=> ($stable(cfg_q) && $stable(limit_q)));

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
        open_o |-> (win_q < WIN_W'(OPEN_CYC)));

    assert_done_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && !$past(rst)) |-> $past(tick));

    assert_upd_gate_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(cfg_q.upd_ok));

endmodule

// File: rtl/kgw_count.sv
module kgw_count #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run_en,
    input  logic             div_en,
    input  logic [CNT_W-1:0] limit,
    input  logic             feed,
    input  logic             clear,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             fire_o
);

    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] count_inc;
    logic             wipe;
    logic             step;
    logic             hit;

    assign wipe      = feed || clear;
    assign count_inc = count_o + CNT_W'(1);
    assign step      = tick && run_en && (!div_en || (&pre_q));
    assign hit       = step && !wipe && (count_inc == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            count_o <= '0;
        end else if (wipe) begin
            pre_q   <= '0;
            count_o <= '0;
        end else if (tick && run_en) begin
            if (div_en) pre_q <= pre_q + 1'b1;
            if (step)   count_o <= hit ? '0 : count_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= hit;
            if (hit)           flag_o <= 1'b1;
            else if (flag_clr) flag_o <= 1'b0;
        end
    end

    assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> flag_o);

    assert_flag_rise_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> fire_o);

    assert_count_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(count_o) && !$past(rst)) |-> ($past(tick) || $past(feed) || $past(clear)));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
    import kgw_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          CNT_W      = 16,
    parameter int          DIV_W      = 8,
    parameter int          OPEN_CYC   = 255,
    parameter int          SYNC_TICKS = 3,
    parameter logic [15:0] LIMIT_RST  = 16'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wd_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdog_rst
);

    localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_COUNT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_LIMIT = ADDR_W'(8);

    logic             wr_ctrl, wr_count, wr_limit;
    logic             unlock_p, feed_p, apply_p;
    logic             open_s, done_s, flag_s;
    logic             act_run, act_div, act_key32;
    cfg_t             cfg_s;
    logic [CNT_W-1:0] limit_s, act_limit, count_s;

    assign wr_ctrl  = bus_we && (bus_addr == OFF_CTRL);
    assign wr_count = bus_we && (bus_addr == OFF_COUNT);
    assign wr_limit = bus_we && (bus_addr == OFF_LIMIT);

    kgw_keyseq u_keyseq (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_count),
        .key_data (bus_wdata),
        .key32    (act_key32),
        .unlock_o (unlock_p),
        .feed_o   (feed_p)
    );

    kgw_cfg #(
        .CNT_W      (CNT_W),
        .OPEN_CYC   (OPEN_CYC),
        .SYNC_TICKS (SYNC_TICKS),
        .LIMIT_RST  (LIMIT_RST)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .tick       (wd_tick),
        .unlock_req (unlock_p),
        .ctrl_wr    (wr_ctrl),
        .limit_wr   (wr_limit),
        .wdata      (bus_wdata),
        .cfg_q      (cfg_s),
        .limit_q    (limit_s),
        .act_run    (act_run),
        .act_div    (act_div),
        .act_key32  (act_key32),
        .act_limit  (act_limit),
        .open_o     (open_s),
        .done_o     (done_s),
        .apply_o    (apply_p)
    );

    kgw_count #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (wd_tick),
        .run_en   (act_run),
        .div_en   (act_div),
        .limit    (act_limit),
        .feed     (feed_p),
        .clear    (apply_p),
        .flag_clr (wr_ctrl && bus_wdata[B_FLAG]),
        .count_o  (count_s),
        .flag_o   (flag_s),
        .fire_o   (wdog_rst)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CTRL)       bus_rdata = ctrl_word(cfg_s, flag_s, open_s, done_s);
        else if (bus_addr == OFF_COUNT) bus_rdata = 32'(count_s);
        else if (bus_addr == OFF_LIMIT) bus_rdata = 32'(limit_s);
    end

    assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(open_s) |-> $past(wr_count));

endmodule

// File: tb/tb_keyguard_wdt.sv
`timescale 1ns/1ps
module tb_keyguard_wdt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wd_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wdog_rst;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_LIM = 4'h8;

    keyguard_wdt dut (
        .clk       (clk),
        .rst       (rst),
        .wd_tick   (wd_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdog_rst  (wdog_rst)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            wd_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        wd_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset_state();
        logic [31:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0000_0420);
        rd(A_CNT, v);  check("R1 count", v, 32'h0);
        rd(A_LIM, v);  check("R1 limit", v, 32'h0000_1000);
        check("R1 wdog_rst", {31'h0, wdog_rst}, 32'h0);
    endtask

    task automatic test_locked_writes();
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_20A3);
        wr(A_LIM, 32'h0000_0055);
        rd(A_CTRL, v); check("R4 ctrl locked", v, 32'h0000_0420);
        rd(A_LIM, v);  check("R4 limit locked", v, 32'h0000_1000);
    endtask

    task automatic test_half_keys();
        logic [31:0] v;
        wr(A_CNT, 32'h0000_D928); wr(A_CNT, 32'h0000_C520);
        wr(A_CNT, 32'h0000_1234); wr(A_CNT, 32'h0000_D928);
        rd(A_CTRL, v); check("R3 reversed/interrupted halves", v[11], 1'b0);
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_B480); wr(A_CNT, 32'h0000_D928);
        rd(A_CTRL, v); check("R3 wrong second half", v[11], 1'b0);
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
        rd(A_CTRL, v); check("R3 ordered halves open", v[11], 1'b1);
    endtask

    task automatic test_window_timeout();
        logic [31:0] v;
        repeat (254) @(posedge clk);
        @(negedge clk);
        rd(A_CTRL, v); check("R5 open at cycle 255", v[11], 1'b1);
        @(posedge clk); @(negedge clk);
        rd(A_CTRL, v); check("R5 closed after 255", v[11], 1'b0);
    endtask

    task automatic test_config_sync();
        logic [31:0] v;
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
        wr(A_LIM, 32'h0000_0005);
        rd(A_CTRL, v); check("R5 limit write keeps open", v[11], 1'b1);
        rd(A_LIM, v);  check("R5 limit stored", v, 32'h5);
        wr(A_CTRL, 32'h0000_00A0);
        rd(A_CTRL, v); check("R5/R6 closed and pending", v, 32'h0000_00A0);
        ticks(2);
        rd(A_CTRL, v); check("R6 still pending after 2 ticks", v[10], 1'b0);
        rd(A_CNT, v);  check("R6 old settings keep counter idle", v, 32'h0);
        ticks(1);
        rd(A_CTRL, v); check("R6 complete after 3 ticks", v, 32'h0000_04A0);
    endtask

    task automatic test_timeout_fire();
        logic [31:0] v;
        ticks(4);
        rd(A_CNT, v);  check("R7 count per tick", v, 32'h4);
        check("R8 no pulse before limit", {31'h0, wdog_rst}, 32'h0);
        ticks(1);
        check("R8 pulse high", {31'h0, wdog_rst}, 32'h1);
        rd(A_CTRL, v); check("R8 flag set", v, 32'h0000_44A0);
        rd(A_CNT, v);  check("R8 count wraps to 0", v, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R8 pulse one cycle", {31'h0, wdog_rst}, 32'h0);
    endtask

    task automatic test_flag_clear();
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_4000);
        rd(A_CTRL, v); check("R10 flag cleared while locked", v, 32'h0000_04A0);
    endtask

    task automatic test_half_refresh();
        logic [31:0] v;
        ticks(3);
        rd(A_CNT, v); check("R7 count 3", v, 32'h3);
        wr(A_CNT, 32'h0000_A602); wr(A_CNT, 32'h0000_B480);
        rd(A_CNT, v); check("R9 half refresh clears", v, 32'h0);
        ticks(2);
        wr(A_CNT, 32'h0000_A602); wr(A_CNT, 32'h0000_1111); wr(A_CNT, 32'h0000_B480);
        rd(A_CNT, v); check("R9 broken refresh ignored", v, 32'h2);
    endtask

    task automatic test_word_mode_prescale();
        logic [31:0] v;
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
        wr(A_LIM, 32'h0000_0064);
        wr(A_CTRL, 32'h0000_30A0);
        ticks(3);
        rd(A_CTRL, v); check("R6 word mode live", v, 32'h0000_34A0);
        rd(A_CNT, v);  check("R6 apply clears count", v, 32'h0);
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
        rd(A_CTRL, v); check("R2 halves rejected in word mode", v[11], 1'b0);
        wr(A_CNT, 32'hD928_C520);
        rd(A_CTRL, v); check("R2 word key opens", v, 32'h0000_3CA0);
        ticks(255);
        rd(A_CNT, v); check("R7 prescaled: no step at 255", v, 32'h0);
        ticks(1);
        rd(A_CNT, v); check("R7 prescaled: step at 256", v, 32'h1);
        ticks(100);
        wr(A_CNT, 32'hB480_A602);
        rd(A_CNT, v); check("R9 word refresh clears", v, 32'h0);
        ticks(255);
        rd(A_CNT, v); check("R9 prescaler cleared by refresh", v, 32'h0);
        ticks(1);
        rd(A_CNT, v); check("R9 step after full period", v, 32'h1);
        wr(A_CNT, 32'hB480_A603);
        rd(A_CNT, v); check("R9 wrong word key ignored", v, 32'h1);
    endtask

    task automatic test_update_lock();
        logic [31:0] v;
        wr(A_CNT, 32'hD928_C520);
        wr(A_CTRL, 32'h0000_2080);
        rd(A_CTRL, v); check("R11 config with bit5 clear", v, 32'h0000_2080);
        ticks(3);
        wr(A_CNT, 32'hD928_C520);
        rd(A_CTRL, v); check("R11 unlock ignored", v, 32'h0000_2480);
        wr(A_CTRL, 32'h0000_2000);
        rd(A_CTRL, v); check("R11 ctrl stays locked", v, 32'h0000_2480);
        do_reset();
        rd(A_CTRL, v); check("R1 reset restores ctrl", v, 32'h0000_0420);
        wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928);
        rd(A_CTRL, v); check("R11 unlock works after reset", v[11], 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        test_reset_state();
        test_locked_writes();
        test_half_keys();
        test_window_timeout();
        test_config_sync();
        test_timeout_fire();
        test_flag_clear();
        test_half_refresh();
        test_word_mode_prescale();
        test_update_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule